// File: doc/BRIEF.md
# Conversion Result Queue with Fill Trigger

This block is the digital back end of a one- or two-channel sampling converter that runs in continuous mode. The analog stage has already digitized its results, and this block receives them on every rising edge of the free-running conversion clock. In two-channel mode both channel results of one sample instant are taken together. They are then written on two consecutive edges, first channel A and then channel B. Each word passes through a fixed pipeline delay and then enters a 16-word result queue. A channel tag bit travels with each word.

A programmable fill threshold drives a data-available output. This output stays high for as long as the queue holds at least the threshold number of words. A host drains the queue through a show-ahead read port. Configuration inputs select single or continuous operation, the channel count and the threshold. A synchronous clear empties the queue, clears the overflow flag, restarts the start-up delay and realigns the channel sequence.

Top module: `adcf_core`

## Requirements
- R1: After reset, `fifo_level` is 0, `fifo_empty` is 1, and both `data_av` and `ovf_flag` are 0.
- R2: While `cfg_single` is 1, no word is written and `fifo_level` never grows. Reads still work.
- R3: With `cfg_single` at 0, the clear edge is followed by exactly PIPE_LAT+T conversion edges with no write, where T is the effective threshold. Each later edge writes one word.
- R4: A tag-0 word written on edge e carries `ch_a_data` as sampled on edge e-PIPE_LAT. A tag-1 word written on edge e carries `ch_b_data` as sampled on edge e-PIPE_LAT-1, so a pair always comes from the same sample instant.
- R5: With `cfg_two_ch` at 0, every word has tag bit `rd_word[DW]` equal to 0 and its data is taken from channel A.
- R6: With `cfg_two_ch` at 1, the tags alternate 0, 1, 0, 1. The first word after a clear has tag 0.
- R7: T is derived from `cfg_trig`. A value above DEPTH becomes DEPTH. A value of 0 becomes the channel count. An odd value in two-channel mode is raised by 1.
- R8: `data_av` is 1 exactly when `fifo_level` is at least T.
- R9: `rd_en` removes the head word. `rd_word` always shows the head word. `rd_en` while the queue is empty has no effect.
- R10: If a write arrives while the queue is full and no read happens in that cycle, the write is dropped, the stored words are kept, and `ovf_flag` is set. `ovf_flag` stays set until a clear.
- R11: A `fifo_clr` edge leaves the queue empty and clears both `ovf_flag` and `data_av`.
- R12: When `cfg_single` returns to 0, the PIPE_LAT+T start-up delay runs again. Words already queued are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, free running |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_single | input | 1 | 1 selects single mode (no capture), 0 selects continuous mode |
| cfg_two_ch | input | 1 | 0 selects one channel, 1 selects two channels |
| cfg_trig | input | LVL_W | Requested fill threshold |
| fifo_clr | input | 1 | Synchronous queue clear |
| ch_a_data | input | DW | Digitized result, channel A |
| ch_b_data | input | DW | Digitized result, channel B |
| rd_en | input | 1 | Pops the head word |
| rd_word | output | DW+1 | Head word: bit DW is the channel tag, the lower bits are data |
| fifo_level | output | LVL_W | Words currently queued |
| fifo_empty | output | 1 | Queue is empty |
| data_av | output | 1 | Fill level is at or above the effective threshold |
| ovf_flag | output | 1 | Sticky flag: a write was dropped because the queue was full |

## Verification
The assertions assume that `cfg_two_ch` and `cfg_trig` change only in the same cycle as a `fifo_clr`. Under that assumption the pipeline always drains during the start-up delay, and the threshold cannot move under a filled queue. The bench changes channel count and threshold only inside its clear task. It raises and lowers `cfg_single` and `rd_en` at falling edges only, and never changes the configuration while words are moving.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
   // Channel tag carried in the top bit of every queued word
   typedef enum logic {
      TAG_CH_A = 1'b0,
      TAG_CH_B = 1'b1
   } ch_tag_e;
endpackage

// File: rtl/adcf_trig_calc.sv
module adcf_trig_calc #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5
) (
   input  logic [LVL_W-1:0] trig_raw,
   input  logic             two_ch,
   output logic [LVL_W-1:0] trig_eff
);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
   localparam logic [LVL_W-1:0] LVL_TWO = LVL_W'(2);

   logic [LVL_W-1:0] clamped;
   logic [LVL_W-1:0] floored;

   always_comb begin
      // clamp first so the odd-value round-up cannot wrap
      clamped  = (trig_raw > LVL_MAX) ? LVL_MAX : trig_raw;
      floored  = (clamped == '0) ? (two_ch ? LVL_TWO : LVL_ONE) : clamped;
      trig_eff = (two_ch && floored[0]) ? floored + LVL_ONE : floored;
   end
endmodule

// File: rtl/adcf_lane_seq.sv
module adcf_lane_seq #(
   parameter int unsigned DW        = 10,
   parameter int unsigned PIPE_LAT  = 8,
   parameter bit          TWO_CH_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          two_ch,
   input  logic [DW-1:0] ch_a,
   input  logic [DW-1:0] ch_b,
   output logic [DW:0]   lane_word
);
   import adcf_pkg::*;

   logic [DW:0] cap_w;

   generate
      if (TWO_CH_EN) begin : g_dual
         logic          sel_q;
         logic [DW-1:0] hold_q;

         // sel_q low: take channel A now and park channel B of the same instant
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q  <= 1'b0;
               hold_q <= '0;
            end else if (restart) begin
               sel_q  <= 1'b0;
            end else begin
               sel_q <= two_ch ? ~sel_q : 1'b0;
               if (!sel_q) hold_q <= ch_b;
            end
         end

         assign cap_w = sel_q ? {TAG_CH_B, hold_q} : {TAG_CH_A, ch_a};
      end else begin : g_mono
         logic unused_b;
         assign unused_b = ^{ch_b, two_ch, restart};
         assign cap_w    = {TAG_CH_A, ch_a};
      end
   endgenerate

   generate
      if (PIPE_LAT == 0) begin : g_nopipe
         assign lane_word = cap_w;
      end else begin : g_pipe
         logic [DW:0] stg_q [PIPE_LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(PIPE_LAT); s++) stg_q[s] <= '0;
            end else begin
               stg_q[0] <= cap_w;
               for (int s = 1; s < int'(PIPE_LAT); s++) stg_q[s] <= stg_q[s-1];
            end
         end

         assign lane_word = stg_q[PIPE_LAT-1];
      end
   endgenerate
endmodule

// File: rtl/adcf_word_fifo.sv
module adcf_word_fifo #(
   parameter int unsigned WW    = 11,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_req,
   input  logic [WW-1:0]    wr_word,
   input  logic             rd_req,
   output logic [WW-1:0]    rd_word,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             ovf
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [WW-1:0]    mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [LVL_W-1:0] lvl_q;
   logic             ovf_q;
   logic             is_full, do_rd, do_wr;

   assign is_full = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign do_rd   = rd_req && !empty && !clr;
   assign do_wr   = wr_req && !clr && (!is_full || do_rd);

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         lvl_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (do_wr) wp_q <= wp_q + 1'b1;
         if (do_rd) rp_q <= rp_q + 1'b1;
         if (do_wr && !do_rd)      lvl_q <= lvl_q + 1'b1;
         else if (do_rd && !do_wr) lvl_q <= lvl_q - 1'b1;
         if (wr_req && !do_wr) ovf_q <= 1'b1;
      end
   end

   assign rd_word = mem[rp_q];
   assign level   = lvl_q;
   assign ovf     = ovf_q;
endmodule

// File: rtl/adcf_core.sv
module adcf_core #(
   parameter int unsigned DW        = 10,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned PIPE_LAT  = 8,
   parameter bit          TWO_CH_EN = 1'b1,
   localparam int unsigned LVL_W    = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_single,
   input  logic             cfg_two_ch,
   input  logic [LVL_W-1:0] cfg_trig,
   input  logic             fifo_clr,
   input  logic [DW-1:0]    ch_a_data,
   input  logic [DW-1:0]    ch_b_data,
   input  logic             rd_en,
   output logic [DW:0]      rd_word,
   output logic [LVL_W-1:0] fifo_level,
   output logic             fifo_empty,
   output logic             data_av,
   output logic             ovf_flag
);
   localparam int unsigned WW   = DW + 1;
   localparam int unsigned HO_W = $clog2(PIPE_LAT + DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("adcf_core: DEPTH must be a power of two of at least 2");
      end
      if ((PIPE_LAT % 2) != 0) begin : g_bad_lat
         $error("adcf_core: PIPE_LAT must be even to keep channel A first");
      end
      if (DW < 1) begin : g_bad_dw
         $error("adcf_core: DW must be at least 1");
      end
   endgenerate

   logic             two_eff;
   logic             restart;
   logic [LVL_W-1:0] trig_eff;
   logic [HO_W-1:0]  ho_q;
   logic [HO_W-1:0]  ho_lim;
   logic             wr_fire;
   logic [DW:0]      lane_word;
   logic             lane_tag;

   assign two_eff = cfg_two_ch & TWO_CH_EN;
   assign restart = fifo_clr | cfg_single;

   adcf_trig_calc #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trig (
      .trig_raw (cfg_trig),
      .two_ch   (two_eff),
      .trig_eff (trig_eff)
   );

   adcf_lane_seq #(.DW(DW), .PIPE_LAT(PIPE_LAT), .TWO_CH_EN(TWO_CH_EN)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .two_ch    (two_eff),
      .ch_a      (ch_a_data),
      .ch_b      (ch_b_data),
      .lane_word (lane_word)
   );

   // start-up delay: pipeline depth plus threshold, restarted by clear or single mode
   assign ho_lim = HO_W'(PIPE_LAT) + HO_W'(trig_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ho_q <= '0;
      else if (restart)       ho_q <= '0;
      else if (ho_q < ho_lim) ho_q <= ho_q + 1'b1;
   end

   assign wr_fire  = !restart && (ho_q >= ho_lim);
   assign lane_tag = lane_word[DW];

   adcf_word_fifo #(.WW(WW), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .wr_req  (wr_fire),
      .wr_word (lane_word),
      .rd_req  (rd_en),
      .rd_word (rd_word),
      .level   (fifo_level),
      .empty   (fifo_empty),
      .ovf     (ovf_flag)
   );

   assign data_av = (fifo_level >= trig_eff);
endmodule

// File: rtl/adcf_core_chk.sv
module adcf_core_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_clr,
   input logic             cfg_single,
   input logic             cfg_two_ch,
   input logic             rd_en,
   input logic [LVL_W-1:0] fifo_level,
   input logic             data_av,
   input logic             ovf_flag,
   input logic             wr_fire,
   input logic             lane_tag
);
   p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fifo_level == '0 && !ovf_flag && !data_av));

   p_single_no_growth_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_single && !fifo_clr) |=> (fifo_level <= $past(fifo_level)));

   p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_clr |=> ({1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + 1'b1));

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !fifo_clr) |=> ovf_flag);

   p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == LVL_W'(DEPTH) && !rd_en && !fifo_clr) |=> (fifo_level == LVL_W'(DEPTH)));

   p_tag_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !cfg_two_ch) |-> !lane_tag);

   p_tag_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && cfg_two_ch && $past(wr_fire) && $past(cfg_two_ch) && !$past(fifo_clr))
         |-> (lane_tag != $past(lane_tag)));

   p_av_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_av) |-> (fifo_level > $past(fifo_level)));
endmodule

bind adcf_core adcf_core_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_clr   (fifo_clr),
   .cfg_single (cfg_single),
   .cfg_two_ch (two_eff),
   .rd_en      (rd_en),
   .fifo_level (fifo_level),
   .data_av    (data_av),
   .ovf_flag   (ovf_flag),
   .wr_fire    (wr_fire),
   .lane_tag   (lane_tag)
);

// File: tb/adcf_core_tb_top.sv
`timescale 1ns/1ps
module adcf_core_tb_top;
   localparam int DW    = 10;
   localparam int DEPTH = 16;
   localparam int LAT   = 8;
   localparam int LVL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_single = 1'b1;
   logic             cfg_two_ch = 1'b0;
   logic [LVL_W-1:0] cfg_trig = '0;
   logic             fifo_clr = 1'b0;
   logic [DW-1:0]    ch_a_data = '0;
   logic [DW-1:0]    ch_b_data = '0;
   logic             rd_en = 1'b0;
   logic [DW:0]      rd_word;
   logic [LVL_W-1:0] fifo_level;
   logic             fifo_empty;
   logic             data_av;
   logic             ovf_flag;

   always #2.5 clk = ~clk;

   adcf_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_two_ch(cfg_two_ch),
      .cfg_trig(cfg_trig), .fifo_clr(fifo_clr), .ch_a_data(ch_a_data),
      .ch_b_data(ch_b_data), .rd_en(rd_en), .rd_word(rd_word),
      .fifo_level(fifo_level), .fifo_empty(fifo_empty), .data_av(data_av),
      .ovf_flag(ovf_flag)
   );

   int checks = 0;
   int fails  = 0;
   int m      = 0;
   bit done   = 1'b0;

   function automatic logic [DW-1:0] fa(int i);
      return DW'(i * 37 + 5);
   endfunction
   function automatic logic [DW-1:0] fb(int i);
      return DW'(i * 11 + 300);
   endfunction

   // edges since the last restart edge (clear or single mode)
   always @(posedge clk) begin
      if (fifo_clr || cfg_single) m <= 0;
      else                        m <= m + 1;
   end
   always @(negedge clk) begin
      ch_a_data <= fa(m + 1);
      ch_b_data <= fb(m + 1);
   end

   // expected j-th word after a restart, from R4/R5/R6
   function automatic int exp_word(bit two, int tle, int j);
      int mm;
      mm = 1 + tle + j;
      if (two && (j % 2 == 1)) return (1 << DW) | int'(fb(mm - 1));
      return int'(fa(mm));
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_clear(bit two, int raw);
      cfg_two_ch = two;
      cfg_trig   = LVL_W'(raw);
      cfg_single = 1'b0;
      fifo_clr   = 1'b1;
      tick();
      fifo_clr   = 1'b0;
   endtask

   task automatic read_check(string req, bit two, int tle, int j);
      chk(req, "head word", int'(rd_word), exp_word(two, tle, j));
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic run_fill(string req, bit two, int raw, int tle, int nw);
      int lvl;
      do_clear(two, raw);
      chk("R11", "level after clear", int'(fifo_level), 0);
      for (int x = 1; x <= LAT + tle; x++) begin
         tick();
         chk("R3", "level during start-up delay", int'(fifo_level), 0);
      end
      tick();
      chk("R3", "first write edge", int'(fifo_level), 1);
      chk("R8", "data_av at level 1", int'(data_av), (1 >= tle) ? 1 : 0);
      for (int l = 2; l <= nw; l++) begin
         tick();
         chk("R3", "one word per edge", int'(fifo_level), l);
         chk("R8", "data_av while filling", int'(data_av), (l >= tle) ? 1 : 0);
      end
      cfg_single = 1'b1;
      tick();
      chk("R2", "single mode holds level", int'(fifo_level), nw);
      tick();
      chk("R2", "single mode holds level again", int'(fifo_level), nw);
      for (int j = 0; j < nw; j++) begin
         chk("R8", "data_av while draining", int'(data_av), ((nw - j) >= tle) ? 1 : 0);
         read_check(req, two, tle, j);
         chk("R9", "level after pop", int'(fifo_level), nw - j - 1);
      end
      lvl = int'(fifo_level);
      chk("R9", "drained empty flag", int'(fifo_empty), (lvl == 0) ? 1 : 0);
   endtask

   task automatic t_reset();
      repeat (3) tick();
      chk("R1", "reset level", int'(fifo_level), 0);
      chk("R1", "reset empty", int'(fifo_empty), 1);
      chk("R1", "reset data_av", int'(data_av), 0);
      chk("R1", "reset ovf", int'(ovf_flag), 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_one_channel();
      run_fill("R5 R4", 1'b0, 4, 4, 6);
   endtask

   task automatic t_two_channel();
      // raw 3 rounds up to 4 (R7); tags alternate from channel A (R6)
      run_fill("R6 R4", 1'b1, 3, 4, 8);
   endtask

   task automatic t_trig_round();
      run_fill("R7 zero to two", 1'b1, 0, 2, 4);
      run_fill("R7 clamp to depth", 1'b0, 31, 16, 16);
   endtask

   task automatic t_read_empty();
      do_clear(1'b0, 2);
      rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      chk("R9", "read when empty level", int'(fifo_level), 0);
      chk("R9", "read when empty flag", int'(fifo_empty), 1);
      cfg_single = 1'b1;
      tick();
   endtask

   task automatic t_overflow();
      do_clear(1'b0, 1);
      repeat (LAT + 1 + 1 + 24) tick();
      chk("R10", "full level", int'(fifo_level), DEPTH);
      chk("R10", "overflow set", int'(ovf_flag), 1);
      chk("R8", "data_av when full", int'(data_av), 1);
      cfg_single = 1'b1;
      tick();
      for (int j = 0; j < DEPTH; j++) read_check("R10", 1'b0, 1, j);
      chk("R10", "overflow sticky after drain", int'(ovf_flag), 1);
      do_clear(1'b0, 1);
      chk("R11", "overflow cleared", int'(ovf_flag), 0);
      chk("R11", "data_av cleared", int'(data_av), 0);
      cfg_single = 1'b1;
      tick();
   endtask

   task automatic t_resume();
      do_clear(1'b0, 2);
      repeat (LAT + 2 + 3) tick();
      chk("R3", "level before pause", int'(fifo_level), 3);
      cfg_single = 1'b1;
      repeat (4) begin
         tick();
         chk("R2", "paused level", int'(fifo_level), 3);
      end
      cfg_single = 1'b0;
      for (int x = 1; x <= LAT + 2; x++) begin
         tick();
         chk("R12", "delay after resume", int'(fifo_level), 3);
      end
      tick();
      chk("R12", "first word after resume", int'(fifo_level), 4);
      cfg_single = 1'b1;
      for (int j = 0; j < 3; j++) read_check("R12", 1'b0, 2, j);
      read_check("R12", 1'b0, 2, 0);
      chk("R9", "empty after resume drain", int'(fifo_empty), 1);
      // clear with words queued
      do_clear(1'b1, 2);
      repeat (LAT + 2 + 3) tick();
      do_clear(1'b1, 2);
      chk("R11", "clear with content", int'(fifo_level), 0);
      cfg_single = 1'b1;
      tick();
   endtask

   initial begin
      t_reset();
      t_one_channel();
      t_two_channel();
      t_trig_round();
      t_read_empty();
      t_overflow();
      t_resume();
      // realignment: two-channel run straight after an odd-length two-channel run
      run_fill("R6 R11 realign", 1'b1, 2, 2, 5);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule